// File: doc/BRIEF.md
# Transmit Packet Queue Controller

This block decides the order in which buffered packets go to a transmit MAC. It moves small packet handles, not packet data. Software first loads a handle into a packet-number register. An enqueue command then appends that handle to a transmit queue. While transmission is enabled, a sequencer takes handles from the head of that queue one at a time and starts the MAC on each. It then waits for the MAC to report either success or failure for that packet.

On success, the block emits a status-write strobe so that the MAC's status word can be stored in the packet's buffer. What happens to the handle next depends on the mode:

- In normal mode, the handle moves into a completion queue. Software reads the completion head and acknowledges it, one entry at a time.
- In auto-release mode, the handle is handed back through a release strobe, so its buffer is freed. A sticky queue-drained flag is raised when the last queued packet has gone.

A failure stops the whole sequence. Transmit-enable is cleared. The failing handle stays visible at the transmit-queue head. A pending-failure condition keeps the transmit interrupt high until software enables transmission again. The re-enabled sequence then retries the same handle first.

All interrupt sources sit in one status vector. A per-bit enable mask gates them onto a single interrupt line.

Top module: `txq_ctrl`

## Requirements
- R1: A write with `pnum_wr` loads `pnum_wdata` into the packet-number register. An `enq_cmd` pulse appends the value the register held before that edge to the tail of the transmit queue. Handles leave the queue in the order they entered.
- R2: `mac_start` is high for one cycle only when all of the following hold: no packet is in flight, transmit-enable is set, the transmit queue is non-empty, the completion queue is not full and `defer_busy` is low. In that cycle `mac_handle` carries the transmit-queue head. No new start occurs until the MAC returns `mac_done`.
- R3: In the cycle `mac_done` arrives for the packet in flight, `stat_wr` is high, `stat_handle` is that packet's handle and `stat_word` equals `mac_status`. This happens whether the packet succeeded or failed. A success removes the handle from the transmit queue. In normal mode, the same success appends the handle to the completion queue.
- R4: `int_stat[0]` (transmit interrupt) is 1 exactly when the completion queue is non-empty or a failure is pending.
- R5: An `ack_wr` pulse removes the completion-queue head. An `ack_wr` pulse while the completion queue is empty changes nothing.
- R6: A `mac_done` with `mac_fail` high does three things: it clears transmit-enable (`txen_o`), it sets the pending-failure condition and it leaves the failing handle at the transmit-queue head. After that, no start occurs until a `cfg_wr` with `cfg_txen`=1. That write clears the pending failure and retries the same handle.
- R7: In auto-release mode (`cfg_autorel`=1), a successful completion pulses `rel_valid` with `rel_handle` set to the handle, and the completion queue is left untouched. When that completion leaves the transmit queue empty, sticky bit `int_stat[1]` is set. A `clr_wr` with `clr_data[1]`=1 clears it. A set and a clear in the same cycle leave the bit set.
- R8: Each queue holds up to 32 handles. An `enq_cmd` while the transmit queue is full is dropped and sets sticky bit `int_stat[2]`. A `clr_wr` with `clr_data[2]`=1 clears that bit.
- R9: `ports_rdata` returns two fields:
  - bits [5:0]: the transmit-queue head; bit 7: transmit queue empty.
  - bits [13:8]: the completion-queue head; bit 15: completion queue empty.
  - Bits 6 and 14 read 0, and a head field reads 0 while its queue is empty.
- R10: `irq` is the OR of `int_stat` ANDed bit by bit with the enable mask. A `mask_wr` pulse loads the mask from `mask_data`.
- R11: After reset: both queues are empty (`ports_rdata` = 16'h8080), `int_stat` = 0, the mask is 0, `irq` = 0, `txen_o` = 0, auto-release mode is off and the packet-number register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pnum_wr | input | 1 | Load the packet-number register |
| pnum_wdata | input | 6 | Handle value for the packet-number register |
| enq_cmd | input | 1 | Append the packet-number register to the transmit queue |
| cfg_wr | input | 1 | Write the control bits |
| cfg_txen | input | 1 | Transmit-enable value |
| cfg_autorel | input | 1 | Auto-release mode value |
| ack_wr | input | 1 | Acknowledge: remove the completion-queue head |
| mask_wr | input | 1 | Load the interrupt enable mask |
| mask_data | input | 3 | Interrupt enable mask value |
| clr_wr | input | 1 | Clear sticky interrupt bits |
| clr_data | input | 3 | Write-one-to-clear pattern (bits 1 and 2 used) |
| defer_busy | input | 1 | Half-duplex deferral still running; holds off a start |
| mac_start | output | 1 | Start the MAC on `mac_handle` |
| mac_handle | output | 6 | Handle of the packet being started |
| mac_done | input | 1 | MAC finished the packet in flight |
| mac_fail | input | 1 | Qualifies `mac_done` as a failure |
| mac_status | input | 16 | Completion status word from the MAC |
| stat_wr | output | 1 | Write the status word into the packet buffer |
| stat_handle | output | 6 | Handle whose buffer receives the status word |
| stat_word | output | 16 | Status word to store |
| rel_valid | output | 1 | Free the buffer of `rel_handle` (auto-release mode) |
| rel_handle | output | 6 | Handle being freed |
| ports_rdata | output | 16 | Queue heads and empty flags |
| int_stat | output | 3 | Interrupt status: [0] transmit, [1] queue drained, [2] overflow |
| irq | output | 1 | Masked interrupt request |
| txen_o | output | 1 | Current transmit-enable state |

## Verification
On every cycle, the assertions check the following:
- the queues are never pushed when full or popped when empty;
- the transmit-queue head cannot change while a packet is in flight;
- no start occurs while a failure is pending, and a failure always drops transmit-enable;
- the overflow and queue-drained bits are sticky, and the transmit interrupt is high whenever the completion queue holds an entry.

Only the bench scenarios can show that handles come out in the order they went in and that a failed packet is retried first after re-enable. The same holds for the point at which the queue-drained bit is raised across a run of auto-released packets, and for the bench's behavioural queue model matching every output on every cycle.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_BUSY = 1'b1
    } seq_state_e;

    localparam int INT_TX    = 0;
    localparam int INT_EMPTY = 1;
    localparam int INT_OVF   = 2;
    localparam int INT_N     = 3;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW:0]             wp;
        logic [AW:0]             rp;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wp[AW-1:0]] = din;
            s_d.wp = s_q.wp + 1'b1;
        end
        if (pop) begin
            s_d.rp = s_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp[AW-1:0]];
    assign empty = (s_q.wp == s_q.rp);
    assign full  = (s_q.wp[AW] != s_q.rp[AW]) && (s_q.wp[AW-1:0] == s_q.rp[AW-1:0]);
    assign count = s_q.wp - s_q.rp;

    AST_FIFO_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8
    AST_FIFO_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R5
endmodule

// File: rtl/txq_seq.sv
module txq_seq
    import txq_pkg::*;
#(
    parameter int HW = 6,
    parameter int SW = 16,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_txen,
    input  logic          cfg_autorel,
    input  logic [HW-1:0] tq_head,
    input  logic          tq_empty,
    input  logic [CW-1:0] tq_count,
    input  logic          enq_ok,
    input  logic          cq_full,
    input  logic          defer_busy,
    input  logic          mac_done,
    input  logic          mac_fail,
    input  logic [SW-1:0] mac_status,
    output logic          mac_start,
    output logic [HW-1:0] mac_handle,
    output logic          stat_wr,
    output logic [HW-1:0] stat_handle,
    output logic [SW-1:0] stat_word,
    output logic          rel_valid,
    output logic [HW-1:0] rel_handle,
    output logic          tq_pop,
    output logic          cq_push,
    output logic          emp_set,
    output logic          fail_pend,
    output logic          txen_o
);
    typedef struct packed {
        seq_state_e st;
        logic       txen;
        logic       autorel;
        logic       fail;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic done_ev, done_ok, done_bad;

    always_comb begin
        s_d       = s_q;
        done_ev   = (s_q.st == SQ_BUSY) && mac_done;
        done_ok   = done_ev && !mac_fail;
        done_bad  = done_ev && mac_fail;
        mac_start = (s_q.st == SQ_IDLE) && s_q.txen && !tq_empty && !cq_full && !defer_busy;

        if (mac_start) s_d.st = SQ_BUSY;
        if (done_ev)   s_d.st = SQ_IDLE;

        if (cfg_wr) begin
            s_d.txen    = cfg_txen;
            s_d.autorel = cfg_autorel;
            if (cfg_txen) s_d.fail = 1'b0;
        end
        if (done_bad) begin
            s_d.txen = 1'b0;
            s_d.fail = 1'b1;
        end

        tq_pop    = done_ok;
        cq_push   = done_ok && !s_q.autorel;
        rel_valid = done_ok && s_q.autorel;
        emp_set   = rel_valid && (tq_count == CW'(1)) && !enq_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, txen: 1'b0, autorel: 1'b0, fail: 1'b0};
        else        s_q <= s_d;
    end

    assign mac_handle  = tq_head;
    assign stat_wr     = done_ev;
    assign stat_handle = tq_head;
    assign stat_word   = mac_status;
    assign rel_handle  = tq_head;
    assign fail_pend   = s_q.fail;
    assign txen_o      = s_q.txen;

    AST_SINGLE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mac_start |=> !mac_start); // R2
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == SQ_BUSY) && $past(s_q.st == SQ_BUSY)) |-> $stable(tq_head)); // R2
    AST_FAIL_DROPS_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
        done_bad |=> (!txen_o && fail_pend)); // R6
    AST_NO_START_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        fail_pend |-> !mac_start); // R6
endmodule

// File: rtl/txq_irq.sv
module txq_irq
    import txq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cq_empty,
    input  logic             fail_pend,
    input  logic             emp_set,
    input  logic             ovf_set,
    input  logic             clr_wr,
    input  logic [INT_N-1:0] clr_data,
    input  logic             mask_wr,
    input  logic [INT_N-1:0] mask_data,
    output logic [INT_N-1:0] int_stat,
    output logic             irq
);
    typedef struct packed {
        logic             emp;
        logic             ovf;
        logic [INT_N-1:0] mask;
    } irq_st_t;

    irq_st_t s_d, s_q;
    logic unused_clr_tx;

    assign unused_clr_tx = clr_data[INT_TX];

    always_comb begin
        s_d = s_q;
        if (clr_wr && clr_data[INT_EMPTY]) s_d.emp = 1'b0;
        if (clr_wr && clr_data[INT_OVF])   s_d.ovf = 1'b0;
        if (emp_set) s_d.emp = 1'b1;
        if (ovf_set) s_d.ovf = 1'b1;
        if (mask_wr) s_d.mask = mask_data;

        int_stat            = '0;
        int_stat[INT_TX]    = !cq_empty || fail_pend;
        int_stat[INT_EMPTY] = s_q.emp;
        int_stat[INT_OVF]   = s_q.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = |(int_stat & s_q.mask);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> int_stat[INT_OVF]); // R8
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (int_stat[INT_EMPTY] && !(clr_wr && clr_data[INT_EMPTY])) |=> int_stat[INT_EMPTY]); // R7
    AST_TXINT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !cq_empty |-> int_stat[INT_TX]); // R4
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int HW      = 6,
    parameter int Q_DEPTH = 32,
    parameter int SW      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pnum_wr,
    input  logic [HW-1:0]     pnum_wdata,
    input  logic              enq_cmd,
    input  logic              cfg_wr,
    input  logic              cfg_txen,
    input  logic              cfg_autorel,
    input  logic              ack_wr,
    input  logic              mask_wr,
    input  logic [INT_N-1:0]  mask_data,
    input  logic              clr_wr,
    input  logic [INT_N-1:0]  clr_data,
    input  logic              defer_busy,
    output logic              mac_start,
    output logic [HW-1:0]     mac_handle,
    input  logic              mac_done,
    input  logic              mac_fail,
    input  logic [SW-1:0]     mac_status,
    output logic              stat_wr,
    output logic [HW-1:0]     stat_handle,
    output logic [SW-1:0]     stat_word,
    output logic              rel_valid,
    output logic [HW-1:0]     rel_handle,
    output logic [2*HW+3:0]   ports_rdata,
    output logic [INT_N-1:0]  int_stat,
    output logic              irq,
    output logic              txen_o
);
    localparam int CW = $clog2(Q_DEPTH) + 1;

    typedef struct packed {
        logic [HW-1:0] pnum;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [HW-1:0] tq_head, cq_head;
    logic          tq_empty, tq_full, cq_empty, cq_full;
    logic [CW-1:0] tq_count, cq_count;
    logic          enq_ok, ovf_set, tq_pop, cq_push, cq_pop, emp_set, fail_pend;

    always_comb begin
        s_d = s_q;
        if (pnum_wr) s_d.pnum = pnum_wdata;
        enq_ok  = enq_cmd && !tq_full;
        ovf_set = enq_cmd && tq_full;
        cq_pop  = ack_wr && !cq_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    txq_fifo #(.W(HW), .DEPTH(Q_DEPTH)) u_tq (
        .clk(clk), .rst_n(rst_n),
        .push(enq_ok), .din(s_q.pnum), .pop(tq_pop),
        .head(tq_head), .empty(tq_empty), .full(tq_full), .count(tq_count)
    );

    txq_fifo #(.W(HW), .DEPTH(Q_DEPTH)) u_cq (
        .clk(clk), .rst_n(rst_n),
        .push(cq_push), .din(tq_head), .pop(cq_pop),
        .head(cq_head), .empty(cq_empty), .full(cq_full), .count(cq_count)
    );

    txq_seq #(.HW(HW), .SW(SW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_txen(cfg_txen), .cfg_autorel(cfg_autorel),
        .tq_head(tq_head), .tq_empty(tq_empty), .tq_count(tq_count), .enq_ok(enq_ok),
        .cq_full(cq_full), .defer_busy(defer_busy),
        .mac_done(mac_done), .mac_fail(mac_fail), .mac_status(mac_status),
        .mac_start(mac_start), .mac_handle(mac_handle),
        .stat_wr(stat_wr), .stat_handle(stat_handle), .stat_word(stat_word),
        .rel_valid(rel_valid), .rel_handle(rel_handle),
        .tq_pop(tq_pop), .cq_push(cq_push), .emp_set(emp_set),
        .fail_pend(fail_pend), .txen_o(txen_o)
    );

    txq_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .cq_empty(cq_empty), .fail_pend(fail_pend),
        .emp_set(emp_set), .ovf_set(ovf_set),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .mask_wr(mask_wr), .mask_data(mask_data),
        .int_stat(int_stat), .irq(irq)
    );

    assign ports_rdata = {cq_empty, 1'b0, (cq_empty ? {HW{1'b0}} : cq_head),
                          tq_empty, 1'b0, (tq_empty ? {HW{1'b0}} : tq_head)};

    AST_CQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cq_count <= CW'(Q_DEPTH)); // R8
    AST_DROP_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set && !tq_pop) |=> (tq_count == CW'(Q_DEPTH))); // R8
endmodule

// File: tb/tb_txq_ctrl.sv
module tb_txq_ctrl;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        pnum_wr = 0, enq_cmd = 0, cfg_wr = 0, cfg_txen = 0, cfg_autorel = 0;
    logic        ack_wr = 0, mask_wr = 0, clr_wr = 0, defer_busy = 0;
    logic        mac_done = 0, mac_fail = 0;
    logic [5:0]  pnum_wdata = 0;
    logic [2:0]  mask_data = 0, clr_data = 0;
    logic [15:0] mac_status = 0;
    logic        mac_start, stat_wr, rel_valid, irq, txen_o;
    logic [5:0]  mac_handle, stat_handle, rel_handle;
    logic [15:0] stat_word, ports_rdata;
    logic [2:0]  int_stat;

    txq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pnum_wr(pnum_wr), .pnum_wdata(pnum_wdata),
        .enq_cmd(enq_cmd), .cfg_wr(cfg_wr), .cfg_txen(cfg_txen), .cfg_autorel(cfg_autorel),
        .ack_wr(ack_wr), .mask_wr(mask_wr), .mask_data(mask_data),
        .clr_wr(clr_wr), .clr_data(clr_data), .defer_busy(defer_busy),
        .mac_start(mac_start), .mac_handle(mac_handle),
        .mac_done(mac_done), .mac_fail(mac_fail), .mac_status(mac_status),
        .stat_wr(stat_wr), .stat_handle(stat_handle), .stat_word(stat_word),
        .rel_valid(rel_valid), .rel_handle(rel_handle),
        .ports_rdata(ports_rdata), .int_stat(int_stat), .irq(irq), .txen_o(txen_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [5:0] mtq[$];
    logic [5:0] mcq[$];
    bit         m_busy = 0, m_txen = 0, m_auto = 0, m_fail = 0, m_emp = 0, m_ovf = 0;
    logic [2:0] m_mask = 0;
    logic [5:0] m_pnum = 0;

    always @(posedge clk) begin
        int  tqs, cqs;
        bit  st, de, ok, bad, acc;
        logic [5:0] h;
        if (!rst_n) begin
            mtq.delete(); mcq.delete();
            m_busy = 0; m_txen = 0; m_auto = 0; m_fail = 0; m_emp = 0; m_ovf = 0;
            m_mask = 0; m_pnum = 0;
        end else begin
            tqs = mtq.size();
            cqs = mcq.size();
            st  = !m_busy && m_txen && tqs > 0 && cqs < DEPTH && !defer_busy;
            de  = m_busy && mac_done;
            ok  = de && !mac_fail;
            bad = de && mac_fail;
            acc = enq_cmd && tqs < DEPTH;
            h   = (tqs > 0) ? mtq[0] : 6'd0;
            if (enq_cmd && !acc) m_ovf = 1;
            else if (clr_wr && clr_data[2]) m_ovf = 0;
            if (ok && m_auto && (tqs - 1 + int'(acc)) == 0) m_emp = 1;
            else if (clr_wr && clr_data[1]) m_emp = 0;
            if (ok && !m_auto) mcq.push_back(h);
            if (ack_wr && cqs > 0) void'(mcq.pop_front());
            if (ok) void'(mtq.pop_front());
            if (acc) mtq.push_back(m_pnum);
            if (st) m_busy = 1;
            else if (de) m_busy = 0;
            if (cfg_wr) begin
                m_txen = cfg_txen;
                m_auto = cfg_autorel;
                if (cfg_txen) m_fail = 0;
            end
            if (bad) begin m_txen = 0; m_fail = 1; end
            if (mask_wr) m_mask = mask_data;
            if (pnum_wr) m_pnum = pnum_wdata;
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        logic [15:0] ep;
        logic [2:0]  ei;
        bit          est, ede, eok;
        if (rst_n) begin
            est = !m_busy && m_txen && mtq.size() > 0 && mcq.size() < DEPTH && !defer_busy;
            ede = m_busy && mac_done;
            eok = ede && !mac_fail;
            ep  = {mcq.size() == 0, 1'b0, (mcq.size() > 0 ? mcq[0] : 6'd0),
                   mtq.size() == 0, 1'b0, (mtq.size() > 0 ? mtq[0] : 6'd0)};
            ei  = {m_ovf, m_emp, (mcq.size() > 0) || m_fail};
            chk("R2 mac_start", 32'(mac_start), 32'(est));
            if (est) chk("R2 mac_handle", 32'(mac_handle), 32'(mtq[0]));
            chk("R3 stat_wr", 32'(stat_wr), 32'(ede));
            if (ede) begin
                chk("R3 stat_handle", 32'(stat_handle), 32'(mtq[0]));
                chk("R3 stat_word", 32'(stat_word), 32'(mac_status));
            end
            chk("R7 rel_valid", 32'(rel_valid), 32'(eok && m_auto));
            if (eok && m_auto) chk("R7 rel_handle", 32'(rel_handle), 32'(mtq[0]));
            chk("R9 ports_rdata", 32'(ports_rdata), 32'(ep));
            chk("R4 int_stat0", 32'(int_stat[0]), 32'(ei[0]));
            chk("R7 int_stat1", 32'(int_stat[1]), 32'(ei[1]));
            chk("R8 int_stat2", 32'(int_stat[2]), 32'(ei[2]));
            chk("R10 irq", 32'(irq), 32'(|(ei & m_mask)));
            chk("R6 txen_o", 32'(txen_o), 32'(m_txen));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        pnum_wr = 0; enq_cmd = 0; cfg_wr = 0; ack_wr = 0; clr_wr = 0; mask_wr = 0;
        mac_done = 0; mac_fail = 0;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic enq(input logic [5:0] h);
        pnum_wr = 1; pnum_wdata = h; tick();
        enq_cmd = 1; tick();
    endtask

    task automatic cfg(input bit en, input bit ar);
        cfg_wr = 1; cfg_txen = en; cfg_autorel = ar; tick();
    endtask

    logic       cap_stat, cap_rel;
    logic [5:0] cap_sh, cap_rh;

    task automatic finish_pkt(input bit fail, input logic [15:0] status);
        for (int i = 0; i < 100 && !m_busy; i++) tick();
        mac_done = 1; mac_fail = fail; mac_status = status;
        settle();
        cap_stat = stat_wr; cap_sh = stat_handle; cap_rel = rel_valid; cap_rh = rel_handle;
        tick();
    endtask

    task automatic ack();
        ack_wr = 1; tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        settle();
        // R11 reset state
        chk("R11 ports reset", 32'(ports_rdata), 32'h8080);
        chk("R11 int_stat reset", 32'(int_stat), 0);
        chk("R11 irq reset", 32'(irq), 0);
        chk("R11 txen reset", 32'(txen_o), 0);
        tick();

        // R1 ordered enqueue while disabled
        enq(6'd5); enq(6'd9); enq(6'd12);
        settle();
        chk("R1 tq head after enqueue", 32'(ports_rdata[7:0]), 32'h05);
        chk("R2 no start while disabled", 32'(mac_start), 0);

        // R2 deferral holds off start
        defer_busy = 1;
        cfg(1, 0);
        tick(); tick();
        settle();
        chk("R2 no start during deferral", 32'(mac_start), 0);
        defer_busy = 0;
        settle();
        chk("R2 start after deferral", 32'(mac_start), 1);
        chk("R2 start handle", 32'(mac_handle), 32'd5);

        // R3 normal-mode completions
        finish_pkt(0, 16'h1111);
        chk("R3 status strobe", 32'(cap_stat), 1);
        chk("R3 status handle", 32'(cap_sh), 32'd5);
        settle();
        chk("R3 cq head after success", 32'(ports_rdata[15:8]), 32'h05);
        chk("R4 tx int with cq entry", 32'(int_stat[0]), 1);
        mask_wr = 1; mask_data = 3'b001; tick();
        settle();
        chk("R10 irq when enabled", 32'(irq), 1);
        finish_pkt(0, 16'h2222);
        finish_pkt(0, 16'h3333);

        // R5 acknowledge pops in order
        ack(); settle();
        chk("R5 cq head after ack", 32'(ports_rdata[15:8]), 32'h09);
        ack(); settle();
        chk("R5 cq head after 2nd ack", 32'(ports_rdata[15:8]), 32'h0C);
        ack(); settle();
        chk("R5 cq empty", 32'(ports_rdata), 32'h8080);
        ack(); settle();
        chk("R5 ack on empty ignored", 32'(ports_rdata), 32'h8080);
        chk("R4 tx int clear", 32'(int_stat[0]), 0);

        // R6 failure stops sequence
        enq(6'd20); enq(6'd21);
        finish_pkt(1, 16'hDEAD);
        chk("R3 status on failure", 32'(cap_stat), 1);
        settle();
        chk("R6 txen cleared", 32'(txen_o), 0);
        chk("R6 failing handle at tq head", 32'(ports_rdata[7:0]), 32'h14);
        chk("R6 tx int on failure", 32'(int_stat[0]), 1);
        tick(); tick(); settle();
        chk("R6 no start after failure", 32'(mac_start), 0);
        cfg(1, 0);
        settle();
        chk("R6 failure cleared by re-enable", 32'(int_stat[0]), 0);
        chk("R6 retry same handle", 32'(mac_handle), 32'd20);
        finish_pkt(0, 16'h0001);
        finish_pkt(0, 16'h0002);
        ack(); ack();

        // R7 auto-release mode
        cfg(1, 1);
        enq(6'd30); enq(6'd31);
        finish_pkt(0, 16'h0A0A);
        chk("R7 release strobe", 32'(cap_rel), 1);
        chk("R7 release handle", 32'(cap_rh), 32'd30);
        settle();
        chk("R7 not drained yet", 32'(int_stat[1]), 0);
        finish_pkt(0, 16'h0B0B);
        settle();
        chk("R7 drained flag", 32'(int_stat[1]), 1);
        chk("R7 cq untouched", 32'(ports_rdata[15]), 1);
        clr_wr = 1; clr_data = 3'b010; tick(); settle();
        chk("R7 drained flag cleared", 32'(int_stat[1]), 0);

        // R8 overflow
        cfg(0, 0);
        for (int i = 0; i < DEPTH + 1; i++) enq(6'(i + 1));
        settle();
        chk("R8 overflow sticky", 32'(int_stat[2]), 1);
        chk("R8 head kept", 32'(ports_rdata[7:0]), 32'h01);
        mask_wr = 1; mask_data = 3'b100; tick(); settle();
        chk("R10 irq from overflow", 32'(irq), 1);
        clr_wr = 1; clr_data = 3'b100; tick(); settle();
        chk("R8 overflow cleared", 32'(int_stat[2]), 0);
        chk("R10 irq drops", 32'(irq), 0);
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule